// File: doc/BRIEF.md
# Early Branch Recovery Selector

This block sits beside the instruction window of an out-of-order core. When some instruction shows behaviour that almost only happens on a mispredicted path (a null dereference, an illegal access and the like), the block gets a one-cycle strobe with that instruction's PC and sequence number. It then decides which older unresolved branch, if any, should be recovered early. If exactly one branch is older, that branch is named. If several are older, a direct-mapped distance table gives the answer. The table is indexed by the low bits of PC XOR global history and holds how far back in sequence numbers the faulty branch sat the last time.

The table learns from one pending record. The first suspicious instruction that has older branches is latched. When a branch older than it later resolves as mispredicted, the difference between the two sequence numbers is written into the table, together with that branch's target if the branch was indirect. All ages are taken relative to the window's oldest sequence number, so 8-bit sequence numbers may wrap freely. Flushing and the predictor itself live elsewhere.

Top module: `wpe_recovery_sel`

The pending record is a two-state machine. State `PEND_IDLE` moves to `PEND_ARMED` on transition CAPTURE, which happens when a strobe arrives with at least one older branch and no flush. State `PEND_ARMED` returns to `PEND_IDLE` on one of three transitions: LEARN (an older branch resolves mispredicted), RETIRE (the latched instruction retires), or DROP (a flush).

## Requirements
- R1: During and right after reset, rec_valid and rec_tgt_valid are 0, every table entry is invalid and the pending record is in PEND_IDLE.
- R2: A strobe with no valid branch older than it produces no request.
- R3: A strobe with exactly one valid older branch produces a request naming that branch's sequence number.
- R4: A strobe with two or more older branches, whose table entry at index (wpe_pc XOR ghist)[IDX_W-1:0] is invalid, produces no request.
- R5: Learning works as follows. While armed, a resolution with res_mispredict=1 whose branch is older than the latched instruction writes distance (latched seq - res_seq) mod 2^SEQ_W, valid, into the latched index. A later strobe with several older branches and a valid entry then requests the branch at (wpe_seq - distance) mod 2^SEQ_W.
- R6: rec_tgt_valid is 1 with rec_tgt equal to the stored target only when the request is made, the entry is valid, it was learned from a resolution with res_indirect=1, and the requested branch equals the predicted sequence number.
- R7: A valid table hit where no older valid branch carries the predicted sequence number produces no request.
- R8: A branch is older than X when (br_seq - head_seq) mod 2^SEQ_W < (X - head_seq) mod 2^SEQ_W, so selection and learning hold across sequence-number wrap.
- R9: Capture happens only from PEND_IDLE, and a flush returns the record to PEND_IDLE and takes priority. Retirement of the latched sequence number also returns it to PEND_IDLE, as does a learn. A strobe in a flush cycle makes no request. After DROP or RETIRE, a later resolution does not write the table.
- R10: A resolution with res_mispredict=0, or one for a branch not older than the latched instruction, leaves the pending record and the table unchanged.
- R11: A request appears as a single-cycle rec_valid pulse in the cycle after its strobe, and at most one request is made per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wpe_valid | input | 1 | Suspicious-instruction strobe |
| wpe_pc | input | PC_W | PC of that instruction |
| wpe_seq | input | SEQ_W | Sequence number of that instruction |
| ghist | input | HIST_W | Global branch history |
| head_seq | input | SEQ_W | Sequence number of the oldest window entry |
| br_valid | input | NUM_BR | Unresolved-branch slot valid bits |
| br_seq | input | NUM_BR*SEQ_W | Slot sequence numbers, slot i at bits [i*SEQ_W +: SEQ_W] |
| res_valid | input | 1 | Branch resolution report |
| res_seq | input | SEQ_W | Resolved branch sequence number |
| res_mispredict | input | 1 | Resolved branch was mispredicted |
| res_indirect | input | 1 | Resolved branch is indirect |
| res_target | input | TGT_W | Correct target of the resolved branch |
| flush | input | 1 | Pipeline flush |
| retire_valid | input | 1 | Retirement report |
| retire_seq | input | SEQ_W | Retiring sequence number |
| rec_valid | output | 1 | Early-recovery request pulse |
| rec_seq | output | SEQ_W | Branch to recover |
| rec_tgt_valid | output | 1 | Predicted target supplied |
| rec_tgt | output | TGT_W | Predicted new fetch target |

## Verification
The bench builds the block with four branch slots. With so few slots, every strobe has a window layout the reference model enumerates directly: none, one, or several older branches, plus younger ones. Sequence numbers and the table index stay at 8 bits, so the walk can place the window head near 240 and have branch and instruction numbers wrap past zero. It also replays the 40/10 learn, 55/25 select case, and then checks that each way of releasing the pending record does stop learning.

// File: rtl/wpe_pkg.sv
package wpe_pkg;

    // Pending-record machine
    typedef enum logic [0:0] {
        PEND_IDLE  = 1'b0,
        PEND_ARMED = 1'b1
    } pend_state_e;

endpackage

// File: rtl/wpe_age_scan.sv
module wpe_age_scan #(
    parameter int SEQ_W  = 8,
    parameter int NUM_BR = 16,
    parameter int CNT_W  = 5
) (
    input  logic [SEQ_W-1:0]        head_seq,
    input  logic [SEQ_W-1:0]        ref_seq,
    input  logic [SEQ_W-1:0]        want_seq,
    input  logic [NUM_BR-1:0]       br_valid,
    input  logic [NUM_BR*SEQ_W-1:0] br_seq,
    output logic [CNT_W-1:0]        older_cnt,
    output logic [SEQ_W-1:0]        first_seq,
    output logic                    want_hit
);

    logic [NUM_BR-1:0] older;
    logic [NUM_BR-1:0] match;
    logic [SEQ_W-1:0]  ref_age;

    assign ref_age = ref_seq - head_seq;

    for (genvar g = 0; g < NUM_BR; g++) begin : g_slot
        logic [SEQ_W-1:0] slot_seq;
        logic [SEQ_W-1:0] slot_age;
        assign slot_seq = br_seq[g*SEQ_W +: SEQ_W];
        assign slot_age = slot_seq - head_seq;
        assign older[g] = br_valid[g] && (slot_age < ref_age);
        assign match[g] = older[g] && (slot_seq == want_seq);
    end

    // Count older slots; the lowest-numbered older slot is reported
    always_comb begin
        older_cnt = '0;
        first_seq = '0;
        for (int i = NUM_BR - 1; i >= 0; i--) begin
            if (older[i]) begin
                older_cnt = older_cnt + 1'b1;
                first_seq = br_seq[i*SEQ_W +: SEQ_W];
            end
        end
    end

    assign want_hit = |match;

endmodule

// File: rtl/wpe_dist_table.sv
module wpe_dist_table #(
    parameter int IDX_W = 8,
    parameter int SEQ_W = 8,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [SEQ_W-1:0] rd_dist,
    output logic             rd_ind,
    output logic [TGT_W-1:0] rd_tgt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEQ_W-1:0] wr_dist,
    input  logic             wr_ind,
    input  logic [TGT_W-1:0] wr_tgt
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] ind_q;
    logic [SEQ_W-1:0] dist_q [DEPTH];
    logic [TGT_W-1:0] tgt_q  [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            dist_q[wr_idx] <= wr_dist;
            ind_q[wr_idx]  <= wr_ind;
            tgt_q[wr_idx]  <= wr_tgt;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_dist  = dist_q[rd_idx];
    assign rd_ind   = ind_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];

endmodule

// File: rtl/wpe_recovery_sel.sv
module wpe_recovery_sel
    import wpe_pkg::*;
#(
    parameter int SEQ_W  = 8,
    parameter int PC_W   = 32,
    parameter int HIST_W = 16,
    parameter int IDX_W  = 8,
    parameter int NUM_BR = 16,
    parameter int TGT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wpe_valid,
    input  logic [PC_W-1:0]         wpe_pc,
    input  logic [SEQ_W-1:0]        wpe_seq,
    input  logic [HIST_W-1:0]       ghist,
    input  logic [SEQ_W-1:0]        head_seq,
    input  logic [NUM_BR-1:0]       br_valid,
    input  logic [NUM_BR*SEQ_W-1:0] br_seq,
    input  logic                    res_valid,
    input  logic [SEQ_W-1:0]        res_seq,
    input  logic                    res_mispredict,
    input  logic                    res_indirect,
    input  logic [TGT_W-1:0]        res_target,
    input  logic                    flush,
    input  logic                    retire_valid,
    input  logic [SEQ_W-1:0]        retire_seq,
    output logic                    rec_valid,
    output logic [SEQ_W-1:0]        rec_seq,
    output logic                    rec_tgt_valid,
    output logic [TGT_W-1:0]        rec_tgt
);

    localparam int CNT_W = $clog2(NUM_BR + 1);

    // Table lookup index from the strobe
    logic [IDX_W-1:0] look_idx;
    logic             unused_hi;
    assign look_idx  = wpe_pc[IDX_W-1:0] ^ ghist[IDX_W-1:0];
    assign unused_hi = ^{wpe_pc[PC_W-1:IDX_W], ghist[HIST_W-1:IDX_W]};

    logic             rd_valid;
    logic [SEQ_W-1:0] rd_dist;
    logic             rd_ind;
    logic [TGT_W-1:0] rd_tgt;
    logic [SEQ_W-1:0] pred_seq;
    assign pred_seq = wpe_seq - rd_dist;

    logic [CNT_W-1:0] older_cnt;
    logic [SEQ_W-1:0] first_seq;
    logic             want_hit;

    wpe_age_scan #(
        .SEQ_W (SEQ_W),
        .NUM_BR(NUM_BR),
        .CNT_W (CNT_W)
    ) scan_i (
        .head_seq (head_seq),
        .ref_seq  (wpe_seq),
        .want_seq (pred_seq),
        .br_valid (br_valid),
        .br_seq   (br_seq),
        .older_cnt(older_cnt),
        .first_seq(first_seq),
        .want_hit (want_hit)
    );

    // Pending record
    pend_state_e      pend_q, pend_d;
    logic [SEQ_W-1:0] pend_seq_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             pend_valid;
    assign pend_valid = (pend_q == PEND_ARMED);

    logic [SEQ_W-1:0] res_age, pend_age;
    logic             learn, retire_hit, capture;
    assign res_age    = res_seq - head_seq;
    assign pend_age   = pend_seq_q - head_seq;
    assign learn      = pend_valid && res_valid && res_mispredict && (res_age < pend_age);
    assign retire_hit = pend_valid && retire_valid && (retire_seq == pend_seq_q);
    assign capture    = wpe_valid && !flush && (older_cnt != '0);

    wpe_dist_table #(
        .IDX_W(IDX_W),
        .SEQ_W(SEQ_W),
        .TGT_W(TGT_W)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (look_idx),
        .rd_valid(rd_valid),
        .rd_dist (rd_dist),
        .rd_ind  (rd_ind),
        .rd_tgt  (rd_tgt),
        .wr_en   (learn),
        .wr_idx  (pend_idx_q),
        .wr_dist (pend_seq_q - res_seq),
        .wr_ind  (res_indirect),
        .wr_tgt  (res_target)
    );

    // Transitions: CAPTURE, LEARN, RETIRE, DROP
    always_comb begin
        pend_d = pend_q;
        unique case (pend_q)
            PEND_IDLE: begin
                if (capture) pend_d = PEND_ARMED;
            end
            PEND_ARMED: begin
                if (flush || learn || retire_hit) pend_d = PEND_IDLE;
            end
            default: pend_d = PEND_IDLE;
        endcase
    end

    // State register with the latched record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= PEND_IDLE;
            pend_seq_q <= '0;
            pend_idx_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (pend_q == PEND_IDLE && pend_d == PEND_ARMED) begin
                pend_seq_q <= wpe_seq;
                pend_idx_q <= look_idx;
            end
        end
    end

    // Recovery choice
    logic             sel_valid;
    logic [SEQ_W-1:0] sel_seq;
    logic             sel_tgt;

    always_comb begin
        sel_valid = 1'b0;
        sel_seq   = '0;
        if (wpe_valid && !flush) begin
            if (older_cnt == CNT_W'(1)) begin
                sel_valid = 1'b1;
                sel_seq   = first_seq;
            end else if (older_cnt > CNT_W'(1) && rd_valid && want_hit) begin
                sel_valid = 1'b1;
                sel_seq   = pred_seq;
            end
        end
        sel_tgt = sel_valid && rd_valid && rd_ind && (sel_seq == pred_seq);
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_valid     <= 1'b0;
            rec_seq       <= '0;
            rec_tgt_valid <= 1'b0;
            rec_tgt       <= '0;
        end else begin
            rec_valid     <= sel_valid;
            rec_seq       <= sel_seq;
            rec_tgt_valid <= sel_tgt;
            rec_tgt       <= sel_tgt ? rd_tgt : '0;
        end
    end

endmodule

// File: rtl/wpe_recovery_sel_chk.sv
module wpe_recovery_sel_chk #(
    parameter int SEQ_W = 8,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wpe_valid,
    input logic             flush,
    input logic             rec_valid,
    input logic [SEQ_W-1:0] rec_seq,
    input logic             rec_tgt_valid,
    input logic [CNT_W-1:0] older_cnt,
    input logic [SEQ_W-1:0] first_seq,
    input logic             pend_valid,
    input logic             learn
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !rec_valid);

    // R11
    rec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(wpe_valid && !flush));

    // R2
    no_older_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(older_cnt != '0));

    // R3
    single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && $past(older_cnt == CNT_W'(1))) |-> (rec_seq == $past(first_seq)));

    // R6
    tgt_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_tgt_valid |-> rec_valid);

    // R9
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pend_valid);

    // R5
    learn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        learn |=> !pend_valid);

endmodule

bind wpe_recovery_sel wpe_recovery_sel_chk #(
    .SEQ_W(SEQ_W),
    .CNT_W(CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wpe_valid    (wpe_valid),
    .flush        (flush),
    .rec_valid    (rec_valid),
    .rec_seq      (rec_seq),
    .rec_tgt_valid(rec_tgt_valid),
    .older_cnt    (older_cnt),
    .first_seq    (first_seq),
    .pend_valid   (pend_valid),
    .learn        (learn)
);

// File: tb/wpe_recovery_sel_tb_top.sv
module wpe_recovery_sel_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wpe_valid = 1'b0;
    logic [31:0] wpe_pc = '0;
    logic [7:0]  wpe_seq = '0;
    logic [15:0] ghist = '0;
    logic [7:0]  head_seq = 8'd5;
    logic [NB-1:0] br_valid = '0;
    logic [7:0]  bseq [NB];
    logic [NB*8-1:0] br_seq;
    logic        res_valid = 1'b0;
    logic [7:0]  res_seq = '0;
    logic        res_mispredict = 1'b0;
    logic        res_indirect = 1'b0;
    logic [31:0] res_target = '0;
    logic        flush = 1'b0;
    logic        retire_valid = 1'b0;
    logic [7:0]  retire_seq = '0;
    logic        rec_valid;
    logic [7:0]  rec_seq;
    logic        rec_tgt_valid;
    logic [31:0] rec_tgt;

    assign br_seq = {bseq[3], bseq[2], bseq[1], bseq[0]};

    always #2 clk = ~clk;

    wpe_recovery_sel #(
        .SEQ_W(8), .PC_W(32), .HIST_W(16), .IDX_W(8), .NUM_BR(NB), .TGT_W(32)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wpe_valid(wpe_valid), .wpe_pc(wpe_pc),
        .wpe_seq(wpe_seq), .ghist(ghist), .head_seq(head_seq),
        .br_valid(br_valid), .br_seq(br_seq), .res_valid(res_valid),
        .res_seq(res_seq), .res_mispredict(res_mispredict),
        .res_indirect(res_indirect), .res_target(res_target), .flush(flush),
        .retire_valid(retire_valid), .retire_seq(retire_seq),
        .rec_valid(rec_valid), .rec_seq(rec_seq),
        .rec_tgt_valid(rec_tgt_valid), .rec_tgt(rec_tgt)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit          m_pv = 0;
    logic [7:0]  m_ps = '0;
    logic [7:0]  m_pi = '0;
    bit          m_tv [256];
    logic [7:0]  m_td [256];
    bit          m_ti [256];
    logic [31:0] m_tt [256];

    function automatic logic [7:0] age(input logic [7:0] s);
        return s - head_seq;
    endfunction

    task automatic tick(input string req);
        int cnt = 0;
        logic [7:0] first = '0;
        logic [7:0] idx, pred;
        bit hit = 0;
        bit lrn;
        bit e_v = 0, e_tv = 0;
        logic [7:0] e_s = '0;
        logic [31:0] e_t = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (br_valid[i] && age(bseq[i]) < age(wpe_seq)) begin
                cnt++;
                first = bseq[i];
            end
        end
        idx  = wpe_pc[7:0] ^ ghist[7:0];
        pred = wpe_seq - m_td[idx];
        for (int i = 0; i < NB; i++)
            if (br_valid[i] && age(bseq[i]) < age(wpe_seq) && bseq[i] == pred) hit = 1;
        if (wpe_valid && !flush) begin
            if (cnt == 1) begin e_v = 1; e_s = first; end
            else if (cnt > 1 && m_tv[idx] && hit) begin e_v = 1; e_s = pred; end
            if (e_v && m_tv[idx] && m_ti[idx] && e_s == pred) begin
                e_tv = 1; e_t = m_tt[idx];
            end
        end
        lrn = m_pv && res_valid && res_mispredict && (age(res_seq) < age(m_ps));
        if (lrn) begin
            m_tv[m_pi] = 1; m_td[m_pi] = m_ps - res_seq;
            m_ti[m_pi] = res_indirect; m_tt[m_pi] = res_target;
        end
        if (m_pv) begin
            if (flush || lrn || (retire_valid && retire_seq == m_ps)) m_pv = 0;
        end else if (wpe_valid && !flush && cnt > 0) begin
            m_pv = 1; m_ps = wpe_seq; m_pi = idx;
        end
        @(posedge clk);
        #1;
        checks++;
        if (rec_valid !== e_v || (e_v && rec_seq !== e_s) ||
            rec_tgt_valid !== e_tv || (e_tv && rec_tgt !== e_t)) begin
            errors++;
            $display("FAIL %s: got v=%0b seq=%0d tv=%0b tgt=%h exp v=%0b seq=%0d tv=%0b tgt=%h",
                     req, rec_valid, rec_seq, rec_tgt_valid, rec_tgt, e_v, e_s, e_tv, e_t);
        end
        wpe_valid = 0; res_valid = 0; flush = 0; retire_valid = 0;
    endtask

    task automatic set_br(input logic [3:0] v, input logic [7:0] s0, s1, s2, s3);
        br_valid = v; bseq[0] = s0; bseq[1] = s1; bseq[2] = s2; bseq[3] = s3;
    endtask

    task automatic wpe(input logic [7:0] s, input logic [31:0] pc, input logic [15:0] gh);
        wpe_valid = 1; wpe_seq = s; wpe_pc = pc; ghist = gh;
    endtask

    task automatic resolve(input logic [7:0] s, input bit mis, input bit ind, input logic [31:0] t);
        res_valid = 1; res_seq = s; res_mispredict = mis; res_indirect = ind; res_target = t;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_tv[i] = 0; m_td[i] = '0; m_ti[i] = 0; m_tt[i] = '0;
        end
        for (int i = 0; i < NB; i++) bseq[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rec_valid !== 1'b0 || rec_tgt_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got v=%0b tv=%0b exp v=0 tv=0", rec_valid, rec_tgt_valid);
        end
        rst_n = 1;
        tick("R1");

        // R2: only a younger branch
        set_br(4'b0001, 8'd50, 0, 0, 0); wpe(8'd40, 32'h1C3, 16'h0F); tick("R2");
        // R3: one older branch, record armed
        set_br(4'b0001, 8'd10, 0, 0, 0); wpe(8'd40, 32'h1C3, 16'h0F); tick("R3");
        // R9: flush drops the record, later resolution does not learn
        flush = 1; tick("R9");
        resolve(8'd10, 1, 1, 32'hDEADBEE0); tick("R9");
        // R4: two older, entry empty
        set_br(4'b0011, 8'd10, 8'd20, 0, 0); wpe(8'd40, 32'h1C3, 16'h0F); tick("R4");
        // R5: learn distance 30 with indirect target
        resolve(8'd10, 1, 1, 32'hDEADBEE0); tick("R5");
        set_br(4'b0011, 8'd25, 8'd35, 0, 0); wpe(8'd55, 32'h1C3, 16'h0F); tick("R5");
        tick("R11");
        // R9: retirement releases the record
        retire_valid = 1; retire_seq = 8'd55; tick("R9");
        resolve(8'd35, 1, 0, 32'h0); tick("R9");
        set_br(4'b0011, 8'd25, 8'd35, 0, 0); wpe(8'd55, 32'h1C3, 16'h0F); tick("R9");
        // R7: predicted branch absent
        set_br(4'b0011, 8'd26, 8'd35, 0, 0); wpe(8'd55, 32'h1C3, 16'h0F); tick("R7");
        // R10: correct resolution and younger mispredict are ignored
        resolve(8'd35, 0, 0, 32'h0); tick("R10");
        resolve(8'd60, 1, 0, 32'h0); tick("R10");
        set_br(4'b0011, 8'd25, 8'd35, 0, 0); wpe(8'd55, 32'h1C3, 16'h0F); tick("R10");
        set_br(4'b0011, 8'd25, 8'd35, 0, 0); wpe(8'd55, 32'h1A3, 16'h0F); tick("R4");
        // R8: wrapped window, non-indirect learn
        flush = 1; tick("R9");
        head_seq = 8'd240;
        set_br(4'b0111, 8'd250, 8'd3, 8'd30, 0); wpe(8'd20, 32'h55, 16'h0); tick("R8");
        resolve(8'd250, 1, 0, 32'h1234); tick("R8");
        set_br(4'b0111, 8'd250, 8'd3, 8'd30, 0); wpe(8'd20, 32'h55, 16'h0); tick("R8");
        set_br(4'b0010, 8'd250, 8'd3, 0, 0); wpe(8'd20, 32'h55, 16'h0); tick("R6");
        // R11: back-to-back strobes then silence
        head_seq = 8'd90;
        set_br(4'b0001, 8'd100, 0, 0, 0); wpe(8'd110, 32'h300, 16'h0); tick("R11");
        wpe(8'd111, 32'h300, 16'h0); tick("R11");
        tick("R11");
        // R2 with flush in the strobe cycle (R9)
        wpe(8'd112, 32'h300, 16'h0); flush = 1; tick("R9");
        tick("R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: got hang exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule